// File: doc/BRIEF.md
# Per-Rank Bad Device Tracker

This block keeps a running health score for every memory rank. Some correctable errors hit both ECC symbols of one x8 DRAM device and arrive with a good link CRC. Each such error raises a small saturating counter for the rank that reported it. The counter's ceiling is a programmable threshold. When an increment lifts a rank's counter to that ceiling, the block records the 5-bit ID of the offending device as the rank's bad-device mark. While the ECC decoder and the patrol scrubber run, all counters decay slowly. Each time the scrubber finishes a number of full passes over memory equal to the threshold, every counter drops by one.

When a rank holds a valid mark, the block reviews each correctable error reported for that rank. An error in any device other than the marked one is reported as an aliased uncorrectable error. Every error report comes back one cycle after it is presented, with its final class. Software can read any rank's counter and mark through a read-select port. Software can also clear a rank's mark. The tracker is live only while enhanced correction is selected and the threshold is non-zero. At all other times its state holds and reports pass through unchanged.

Top module: `rank_fault_tracker`

## Requirements
- R1: The tracker is active only when `enhMode` is 1 and `threshold` is non-zero. While it is inactive, counters, marks (except software clears) and the pass count hold their values, and correctable reports are never reclassified.
- R2: Each rank's counter is CNT_W bits wide (default 4) and resets to 0. It never goes below 0. An increment never takes it above `threshold`, and once it equals `threshold` further qualifying errors leave it unchanged.
- R3: A rank's counter increments by one only on a report with `evValid`=1, `evCorrectable`=1, `evDualSym`=1 and `evCrcOk`=1 that is not reclassified as aliased. Only the rank given by `evRank` changes.
- R4: The tracker counts `passDone` pulses while it is active. On the pulse that brings the count to `threshold`, every non-zero counter decrements by one and the pass count restarts from 0.
- R5: When an increment brings a rank's counter to `threshold` and the rank has no valid mark, the mark becomes valid and holds `evDevice`. A valid mark is never overwritten by a later saturation.
- R6: A `clrMark` pulse clears the mark-valid bit of rank `clrRank` and leaves every counter unchanged.
- R7: The report outputs `rptValid`, `rptCorrectable` and `rptAliased` are registered one cycle after the input report. If the rank is marked and the tracker is active, a correctable report whose `evDevice` differs from the mark gives `rptCorrectable`=0 and `rptAliased`=1. A report in the marked device gives `rptCorrectable`=1. An uncorrectable input gives 0 on both flags.
- R8: If a qualifying increment and a decay decrement reach the same counter in the same cycle, that counter keeps its value.
- R9: The threshold may be as low as 1. With `threshold`=1, a single qualifying error marks the rank, and every single pass pulse decays the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enhMode | input | 1 | Enhanced correction mode select |
| threshold | input | CNT_W | Counter ceiling and decay period in passes |
| passDone | input | 1 | One-cycle pulse per completed full patrol pass |
| evValid | input | 1 | Error report present |
| evRank | input | RANK_W | Rank of the report |
| evCorrectable | input | 1 | ECC classed the error as correctable |
| evDualSym | input | 1 | Both symbols of one x8 device were in error |
| evCrcOk | input | 1 | Link CRC of the transfer was good |
| evDevice | input | DEV_W | Device ID of the erroneous symbol(s) |
| clrMark | input | 1 | Clear the mark of rank `clrRank` |
| clrRank | input | RANK_W | Rank whose mark is cleared |
| rdRank | input | RANK_W | Rank selected for readout |
| rdCount | output | CNT_W | Counter of the selected rank |
| rdMarkValid | output | 1 | Mark-valid bit of the selected rank |
| rdMarkDev | output | DEV_W | Marked device of the selected rank |
| rptValid | output | 1 | Registered report present |
| rptCorrectable | output | 1 | Report remains correctable |
| rptAliased | output | 1 | Report reclassified as aliased uncorrectable |

## Verification
The counting path is tested with reports that fail exactly one qualifying condition: bad CRC, a single symbol, or uncorrectable. Only the fully qualified report moves the counter, and only the counter of its own rank. Reclassification is tested with reports in the marked device, in another device, in an unmarked rank, and with the tracker disabled. These cases tell a device compare apart from a plain rank-marked test. Decay is tested with pulse counts just short of the threshold, equal to it, and sent while inactive, and again at threshold 1. A decay pulse placed in the same cycle as an increment checks that the collision leaves the counter unchanged.

// File: rtl/rank_fault_pkg.sv
package rank_fault_pkg;

  // Strobes from control to datapath for one clock cycle
  typedef struct packed {
    logic incEn;    // qualifying increment for the event rank
    logic decAll;   // decay every non-zero counter
    logic latchEn;  // record event device as the rank's mark
    logic aliased;  // reclassify the current report
    logic clrEn;    // software clear of one mark
  } strobe_t;

endpackage

// File: rtl/rank_fault_ctrl.sv
module rank_fault_ctrl
  import rank_fault_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DEV_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enhMode,
  input  logic [CNT_W-1:0] threshold,
  input  logic             passDone,
  input  logic             evValid,
  input  logic             evCorrectable,
  input  logic             evDualSym,
  input  logic             evCrcOk,
  input  logic [DEV_W-1:0] evDevice,
  input  logic             clrMark,
  input  logic [CNT_W-1:0] curCount,
  input  logic             curMarkValid,
  input  logic [DEV_W-1:0] curMarkDev,
  output strobe_t          strb,
  output logic             active
);

  logic [CNT_W-1:0] passCnt;
  logic [CNT_W:0]   passNext;
  logic [CNT_W:0]   countNext;
  logic             corrHit;

  always_comb begin
    active    = enhMode && (threshold != '0);
    passNext  = {1'b0, passCnt} + 1'b1;
    countNext = {1'b0, curCount} + 1'b1;
    corrHit   = active && evValid && evCorrectable;

    strb.aliased = corrHit && curMarkValid && (evDevice != curMarkDev);
    strb.decAll  = active && passDone && (passNext >= {1'b0, threshold});
    strb.incEn   = corrHit && evDualSym && evCrcOk && !strb.aliased
                   && (curCount < threshold);
    strb.latchEn = strb.incEn && !strb.decAll && !curMarkValid
                   && (countNext == {1'b0, threshold});
    strb.clrEn   = clrMark;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passCnt <= '0;
    end else if (active && passDone) begin
      passCnt <= strb.decAll ? '0 : passNext[CNT_W-1:0];
    end
  end

  AST_DEC_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    strb.decAll |-> (passDone && enhMode && threshold != '0)); // R4

  AST_LATCH_NEEDS_INC: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchEn |-> (evValid && evCorrectable && evDualSym && evCrcOk)); // R5

endmodule

// File: rtl/rank_fault_dpath.sv
module rank_fault_dpath
  import rank_fault_pkg::*;
#(
  parameter int NUM_RANKS = 8,
  parameter int CNT_W     = 4,
  parameter int DEV_W     = 5,
  parameter int RANK_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              active,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              evValid,
  input  logic              evCorrectable,
  input  logic [RANK_W-1:0] evRank,
  input  logic [DEV_W-1:0]  evDevice,
  input  logic [RANK_W-1:0] clrRank,
  input  logic [RANK_W-1:0] rdRank,
  output logic [CNT_W-1:0]  curCount,
  output logic              curMarkValid,
  output logic [DEV_W-1:0]  curMarkDev,
  output logic [CNT_W-1:0]  rdCount,
  output logic              rdMarkValid,
  output logic [DEV_W-1:0]  rdMarkDev,
  output logic              rptValid,
  output logic              rptCorrectable,
  output logic              rptAliased
);

  logic [CNT_W-1:0] cnt       [NUM_RANKS];
  logic             markValid [NUM_RANKS];
  logic [DEV_W-1:0] markDev   [NUM_RANKS];

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic incHit;
    logic latchHit;
    logic clrHit;

    always_comb begin
      incHit   = strb.incEn   && (evRank  == RANK_W'(r));
      latchHit = strb.latchEn && (evRank  == RANK_W'(r));
      clrHit   = strb.clrEn   && (clrRank == RANK_W'(r));
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt[r] <= '0;
      end else if (incHit && !strb.decAll) begin
        cnt[r] <= cnt[r] + 1'b1;
      end else if (!incHit && strb.decAll && cnt[r] != '0) begin
        cnt[r] <= cnt[r] - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        markValid[r] <= 1'b0;
        markDev[r]   <= '0;
      end else if (latchHit) begin
        markValid[r] <= 1'b1;
        markDev[r]   <= evDevice;
      end else if (clrHit) begin
        markValid[r] <= 1'b0;
      end
    end

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rstN)
      incHit |=> cnt[r] <= $past(threshold)); // R2

    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[r] == '0 && !incHit) |=> cnt[r] == '0); // R2

    AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !active |=> $stable(cnt[r])); // R1

    AST_MARK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (markValid[r] && !clrHit) |=> (markValid[r] && $stable(markDev[r]))); // R5

    AST_MARK_AT_SAT: assert property (@(posedge clk) disable iff (!rstN)
      $rose(markValid[r]) |-> cnt[r] == $past(threshold)); // R5

    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (incHit && strb.decAll) |=> $stable(cnt[r])); // R8
  end

  always_comb begin
    curCount     = cnt[evRank];
    curMarkValid = markValid[evRank];
    curMarkDev   = markDev[evRank];
    rdCount      = cnt[rdRank];
    rdMarkValid  = markValid[rdRank];
    rdMarkDev    = markDev[rdRank];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rptValid       <= 1'b0;
      rptCorrectable <= 1'b0;
      rptAliased     <= 1'b0;
    end else begin
      rptValid       <= evValid;
      rptCorrectable <= evValid && evCorrectable && !strb.aliased;
      rptAliased     <= evValid && strb.aliased;
    end
  end

  AST_ALIAS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    rptAliased |-> (rptValid && !rptCorrectable)); // R7

endmodule

// File: rtl/rank_fault_tracker.sv
module rank_fault_tracker
  import rank_fault_pkg::*;
#(
  parameter int NUM_RANKS = 8,
  parameter int CNT_W     = 4,
  parameter int DEV_W     = 5,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enhMode,
  input  logic [CNT_W-1:0]  threshold,
  input  logic              passDone,
  input  logic              evValid,
  input  logic [RANK_W-1:0] evRank,
  input  logic              evCorrectable,
  input  logic              evDualSym,
  input  logic              evCrcOk,
  input  logic [DEV_W-1:0]  evDevice,
  input  logic              clrMark,
  input  logic [RANK_W-1:0] clrRank,
  input  logic [RANK_W-1:0] rdRank,
  output logic [CNT_W-1:0]  rdCount,
  output logic              rdMarkValid,
  output logic [DEV_W-1:0]  rdMarkDev,
  output logic              rptValid,
  output logic              rptCorrectable,
  output logic              rptAliased
);

  strobe_t          strb;
  logic             active;
  logic [CNT_W-1:0] curCount;
  logic             curMarkValid;
  logic [DEV_W-1:0] curMarkDev;

  rank_fault_ctrl #(.CNT_W(CNT_W), .DEV_W(DEV_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enhMode      (enhMode),
    .threshold    (threshold),
    .passDone     (passDone),
    .evValid      (evValid),
    .evCorrectable(evCorrectable),
    .evDualSym    (evDualSym),
    .evCrcOk      (evCrcOk),
    .evDevice     (evDevice),
    .clrMark      (clrMark),
    .curCount     (curCount),
    .curMarkValid (curMarkValid),
    .curMarkDev   (curMarkDev),
    .strb         (strb),
    .active       (active)
  );

  rank_fault_dpath #(
    .NUM_RANKS(NUM_RANKS), .CNT_W(CNT_W), .DEV_W(DEV_W), .RANK_W(RANK_W)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .active        (active),
    .threshold     (threshold),
    .evValid       (evValid),
    .evCorrectable (evCorrectable),
    .evRank        (evRank),
    .evDevice      (evDevice),
    .clrRank       (clrRank),
    .rdRank        (rdRank),
    .curCount      (curCount),
    .curMarkValid  (curMarkValid),
    .curMarkDev    (curMarkDev),
    .rdCount       (rdCount),
    .rdMarkValid   (rdMarkValid),
    .rdMarkDev     (rdMarkDev),
    .rptValid      (rptValid),
    .rptCorrectable(rptCorrectable),
    .rptAliased    (rptAliased)
  );

endmodule

// File: tb/rank_fault_tracker_test.sv
module rank_fault_tracker_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enhMode = 1'b0;
  logic [3:0] threshold = '0;
  logic       passDone = 1'b0;
  logic       evValid = 1'b0;
  logic [2:0] evRank = '0;
  logic       evCorrectable = 1'b0;
  logic       evDualSym = 1'b0;
  logic       evCrcOk = 1'b0;
  logic [4:0] evDevice = '0;
  logic       clrMark = 1'b0;
  logic [2:0] clrRank = '0;
  logic [2:0] rdRank = '0;
  logic [3:0] rdCount;
  logic       rdMarkValid;
  logic [4:0] rdMarkDev;
  logic       rptValid;
  logic       rptCorrectable;
  logic       rptAliased;

  int nChecks = 0;
  int nFails  = 0;
  logic gotValid, gotCorr, gotAlias;

  rank_fault_tracker uut (
    .clk(clk), .rstN(rstN), .enhMode(enhMode), .threshold(threshold),
    .passDone(passDone), .evValid(evValid), .evRank(evRank),
    .evCorrectable(evCorrectable), .evDualSym(evDualSym), .evCrcOk(evCrcOk),
    .evDevice(evDevice), .clrMark(clrMark), .clrRank(clrRank),
    .rdRank(rdRank), .rdCount(rdCount), .rdMarkValid(rdMarkValid),
    .rdMarkDev(rdMarkDev), .rptValid(rptValid),
    .rptCorrectable(rptCorrectable), .rptAliased(rptAliased)
  );

  always #5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One report, with optional pass pulse in the same cycle
  task automatic sendEv(int rank, bit corr, bit dual, bit crc, int dev, bit pass);
    @(negedge clk);
    evValid = 1'b1; evRank = 3'(rank); evCorrectable = corr;
    evDualSym = dual; evCrcOk = crc; evDevice = 5'(dev); passDone = pass;
    @(negedge clk);
    gotValid = rptValid; gotCorr = rptCorrectable; gotAlias = rptAliased;
    evValid = 1'b0; evCorrectable = 1'b0; evDualSym = 1'b0; evCrcOk = 1'b0;
    passDone = 1'b0;
  endtask

  task automatic passes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); passDone = 1'b1;
      @(negedge clk); passDone = 1'b0;
    end
  endtask

  task automatic chkRank(string req, int rank, int expCnt, int expValid, int expDev);
    rdRank = 3'(rank);
    #1;
    chk(req, $sformatf("count rank %0d", rank), int'(rdCount), expCnt);
    chk(req, $sformatf("mark valid rank %0d", rank), int'(rdMarkValid), expValid);
    if (expValid != 0)
      chk(req, $sformatf("mark dev rank %0d", rank), int'(rdMarkDev), expDev);
  endtask

  task automatic chkRpt(string req, int v, int c, int a);
    chk(req, "rptValid", int'(gotValid), v);
    chk(req, "rptCorrectable", int'(gotCorr), c);
    chk(req, "rptAliased", int'(gotAlias), a);
  endtask

  task automatic t_reset();
    for (int r = 0; r < 8; r++) chkRank("R2", r, 0, 0, 0);
    chk("R7", "rptValid at reset", int'(rptValid), 0);
  endtask

  task automatic t_inactive();
    enhMode = 1'b0; threshold = 4'd3;
    sendEv(1, 1, 1, 1, 2, 0);
    chkRank("R1", 1, 0, 0, 0);
    chkRpt("R1", 1, 1, 0);
    enhMode = 1'b1; threshold = 4'd0;
    sendEv(1, 1, 1, 1, 2, 0);
    chkRank("R1", 1, 0, 0, 0);
    threshold = 4'd3;
  endtask

  task automatic t_incGating();
    sendEv(2, 1, 1, 0, 7, 0); chkRank("R3", 2, 0, 0, 0);
    sendEv(2, 1, 0, 1, 7, 0); chkRank("R3", 2, 0, 0, 0);
    sendEv(2, 0, 1, 1, 7, 0); chkRank("R3", 2, 0, 0, 0);
    chkRpt("R7", 1, 0, 0);
    sendEv(2, 1, 1, 1, 7, 0); chkRank("R3", 2, 1, 0, 0);
    chkRank("R3", 3, 0, 0, 0);
  endtask

  task automatic t_saturate();
    sendEv(2, 1, 1, 1, 7, 0); chkRank("R5", 2, 2, 0, 0);
    sendEv(2, 1, 1, 1, 7, 0); chkRank("R5", 2, 3, 1, 7);
    sendEv(2, 1, 1, 1, 7, 0); chkRank("R2", 2, 3, 1, 7);
  endtask

  task automatic t_alias();
    sendEv(2, 1, 0, 1, 4, 0); chkRpt("R7", 1, 0, 1);
    sendEv(2, 1, 1, 1, 9, 0); chkRpt("R7", 1, 0, 1);
    chkRank("R7", 2, 3, 1, 7);
    sendEv(2, 1, 0, 1, 7, 0); chkRpt("R7", 1, 1, 0);
    sendEv(2, 0, 0, 1, 4, 0); chkRpt("R7", 1, 0, 0);
    sendEv(3, 1, 0, 1, 4, 0); chkRpt("R7", 1, 1, 0);
    enhMode = 1'b0;
    sendEv(2, 1, 0, 1, 4, 0); chkRpt("R1", 1, 1, 0);
    chkRank("R1", 2, 3, 1, 7);
    enhMode = 1'b1;
  endtask

  task automatic t_decay();
    sendEv(3, 1, 1, 1, 1, 0); chkRank("R3", 3, 1, 0, 0);
    passes(2);
    chkRank("R4", 2, 3, 1, 7); chkRank("R4", 3, 1, 0, 0);
    passes(1);
    chkRank("R4", 2, 2, 1, 7); chkRank("R4", 3, 0, 0, 0);
    chkRank("R2", 0, 0, 0, 0);
    enhMode = 1'b0;
    passes(3);
    chkRank("R1", 2, 2, 1, 7);
    enhMode = 1'b1;
    passes(3);
    chkRank("R4", 2, 1, 1, 7); chkRank("R2", 3, 0, 0, 0);
  endtask

  task automatic t_collide();
    passes(2);
    chkRank("R4", 2, 1, 1, 7);
    sendEv(2, 1, 1, 1, 7, 1);
    chkRank("R8", 2, 1, 1, 7);
  endtask

  task automatic t_clear();
    @(negedge clk); clrMark = 1'b1; clrRank = 3'd2;
    @(negedge clk); clrMark = 1'b0;
    chkRank("R6", 2, 1, 0, 0);
    sendEv(2, 1, 1, 1, 4, 0); chkRpt("R6", 1, 1, 0);
    chkRank("R6", 2, 2, 0, 0);
    sendEv(2, 1, 1, 1, 4, 0); chkRank("R5", 2, 3, 1, 4);
  endtask

  task automatic t_thr1();
    threshold = 4'd1;
    sendEv(5, 1, 1, 1, 11, 0); chkRank("R9", 5, 1, 1, 11);
    passes(1);
    chkRank("R9", 5, 0, 1, 11); chkRank("R9", 2, 2, 1, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_inactive();
    t_incGating();
    t_saturate();
    t_alias();
    t_decay();
    t_collide();
    t_clear();
    t_thr1();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule